// File: doc/BRIEF.md
# Sample Demultiplexer with Data-Ready Clock

This block accepts one sample per clock on an input bus and spreads the stream over two output ports. In pair mode, successive samples alternate between port A and port B. The two port paths have different pipeline depths, so each pair leaves the block in the same cycle and the pair rate is half the sample rate. In single mode, every sample goes to port A. Port B then holds zero and its enable is low, so a downstream driver can put that port into high impedance.

Alongside the data, the block produces a data-ready clock at half or a quarter of the sample rate. Its rising edge sits in the middle of a valid data interval. A data-ready reset request realigns the divider and the pair phase. The request passes through a two-flop synchroniser, and it counts only when it is seen on two edges in a row, so a one-cycle glitch is ignored.

Two state machines do the work. The alignment machine has the states AL_RUN, AL_ARMED and AL_HOLD:
- AL_RUN goes to AL_ARMED when the synchronised request is high.
- AL_ARMED goes to AL_HOLD when the request is still high, and it issues the realign pulse on that transition. If the request has dropped, AL_ARMED returns to AL_RUN.
- AL_HOLD returns to AL_RUN once the request is low.

The phase machine steps around the ring PH_A0, PH_B0, PH_A1, PH_B1 and back to PH_A0. Reset or the realign pulse sends it straight to PH_A0. An edge taken in an A slot captures a port-A sample. An edge taken in a B slot completes a pair.

Top module: `smp_demux_top`

In the requirements, "d" counts clock edges since the last alignment edge. The alignment edge is d=0: either the release of reset or the edge on which a realignment takes effect. The first edge after it is d=1.

## Requirements
- R1: While rst_n is low, port_a and port_b are all zeros, and port_b_en and dr_clk are low.
- R2: In pair mode (ratio_sel=1), the sample taken on edge d=1+2j goes to port A and the sample taken on edge d=2+2j goes to port B of the same pair.
- R3: The port-A sample appears 4 edges after capture and the port-B sample 3 edges after capture. Both appear after edge d=5+2j and hold for two cycles.
- R4: In single mode (ratio_sel=0), port_a shows the sample taken 4 edges earlier, and changes on every edge.
- R5: port_b_en equals ratio_sel as sampled on the most recent edge. While port_b_en is low, port_b is all zeros.
- R6: With rate_sel=0 (half rate), dr_clk is high after edges with even d≥2 and low after edges with odd d.
- R7: With rate_sel=1 (quarter rate), dr_clk is high after edges with d mod 4 equal to 2 or 3, and low otherwise.
- R8: In pair mode, with d≥6, ports A and B do not change in the cycle in which dr_clk rises.
- R9: If dr_rst is sampled high on two consecutive edges t and t+1, edge t+3 becomes the new alignment edge, and dr_clk is low after it.
- R10: If dr_rst is high on a single edge only, no realignment happens.
- R11: After any alignment edge, the sample taken on d=1 is the first one to reach port A, and it appears after edge d=5.
- R12: A dr_rst held high for many edges realigns exactly once. A further realignment needs dr_rst to be low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | DW | Incoming sample, one per clock |
| ratio_sel | input | 1 | 1 selects pair mode, 0 selects single mode |
| rate_sel | input | 1 | 0 selects data-ready at half rate, 1 selects quarter rate |
| dr_rst | input | 1 | Data-ready realignment request |
| port_a | output | DW | First sample of each pair, or every sample in single mode |
| port_b | output | DW | Second sample of each pair, zero in single mode |
| port_b_en | output | 1 | High when port B carries data |
| dr_clk | output | 1 | Data-ready clock |

## Verification
A realignment can land on the same edge as a pair completion or a data-ready transition. The resulting phase must be exactly the one the request dictates, whatever the divider was doing at that moment. The bench provokes this by sweeping the request start over all four divider slots, and by firing requests at random points in randomised runs of mode and rate. It judges the result by checking three things: the first pair after realignment, the low data-ready level on the alignment edge, and the data-ready pattern from then on. A single-edge glitch and a long-held request are checked the same way: the phase they leave behind must match the one that was in force before, or the single realignment the request calls for.

// File: rtl/smp_demux_pkg.sv
package smp_demux_pkg;

    // Alignment request qualifier states
    typedef enum logic [1:0] {
        AL_RUN   = 2'd0,
        AL_ARMED = 2'd1,
        AL_HOLD  = 2'd2
    } align_state_e;

    // Output phase ring: A slots capture the first sample of a pair,
    // B slots complete the pair
    typedef enum logic [1:0] {
        PH_A0 = 2'd0,
        PH_B0 = 2'd1,
        PH_A1 = 2'd2,
        PH_B1 = 2'd3
    } slot_e;

    localparam logic RATIO_SINGLE = 1'b0;
    localparam logic RATIO_PAIR   = 1'b1;
    localparam logic RATE_HALF    = 1'b0;
    localparam logic RATE_QUARTER = 1'b1;

endpackage

// File: rtl/smp_dr_sync.sv
module smp_dr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr <= {sr[STAGES-2:0], din};
        end
    end

    assign dout = sr[STAGES-1];

endmodule

// File: rtl/smp_align_fsm.sv
module smp_align_fsm
    import smp_demux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic realign
);

    align_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= AL_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            AL_RUN:   if (req) state_nxt = AL_ARMED;
            AL_ARMED: state_nxt = req ? AL_HOLD : AL_RUN;
            AL_HOLD:  if (!req) state_nxt = AL_RUN;
            default:  state_nxt = AL_RUN;
        endcase
    end

    // The request counts once it is seen on two edges in a row
    always_comb begin
        realign = 1'b0;
        unique case (state)
            AL_ARMED: realign = req;
            default:  realign = 1'b0;
        endcase
    end

endmodule

// File: rtl/smp_phase_div.sv
module smp_phase_div
    import smp_demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  realign,
    input  logic  rate_sel,
    output slot_e slot,
    output logic  dr_clk
);

    slot_e slot_nxt;
    logic  dr_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= PH_A0;
        end else begin
            slot <= slot_nxt;
        end
    end

    always_comb begin
        slot_nxt = slot;
        unique case (slot)
            PH_A0: slot_nxt = PH_B0;
            PH_B0: slot_nxt = PH_A1;
            PH_A1: slot_nxt = PH_B1;
            PH_B1: slot_nxt = PH_A0;
        endcase
        if (realign) slot_nxt = PH_A0;
    end

    // Data-ready level decoded from the slot being entered, then registered
    always_comb begin
        dr_nxt = 1'b0;
        unique case (slot_nxt)
            PH_A0: dr_nxt = (rate_sel == RATE_HALF);
            PH_B0: dr_nxt = 1'b0;
            PH_A1: dr_nxt = 1'b1;
            PH_B1: dr_nxt = (rate_sel == RATE_QUARTER);
        endcase
        if (realign) dr_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_clk <= 1'b0;
        end else begin
            dr_clk <= dr_nxt;
        end
    end

endmodule

// File: rtl/smp_demux_path.sv
module smp_demux_path #(
    parameter int DW    = 8,
    parameter int LAT_A = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_in,
    input  logic          pair_mode,
    input  logic          b_slot,
    output logic [DW-1:0] pa,
    output logic [DW-1:0] pb
);

    // Stages after the pair register; the last one drives the ports
    localparam int TAIL = LAT_A - 1;

    logic [DW-1:0] a_hold;
    logic [DW-1:0] st_a, st_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hold <= '0;
            st_a   <= '0;
            st_b   <= '0;
        end else begin
            if (!pair_mode || !b_slot) begin
                a_hold <= smp_in;
            end
            if (!pair_mode || b_slot) begin
                st_a <= a_hold;
                st_b <= pair_mode ? smp_in : '0;
            end
        end
    end

    for (genvar i = 0; i < TAIL; i++) begin : g_tail
        logic [DW-1:0] a_q, b_q;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_q <= '0;
                    b_q <= '0;
                end else begin
                    a_q <= st_a;
                    b_q <= st_b;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_q <= '0;
                    b_q <= '0;
                end else begin
                    a_q <= g_tail[i-1].a_q;
                    b_q <= g_tail[i-1].b_q;
                end
            end
        end
    end

    assign pa = g_tail[TAIL-1].a_q;
    assign pb = g_tail[TAIL-1].b_q;

endmodule

// File: rtl/smp_demux_top.sv
module smp_demux_top
    import smp_demux_pkg::*;
#(
    parameter int DW          = 8,
    parameter int LAT_A       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_in,
    input  logic          ratio_sel,
    input  logic          rate_sel,
    input  logic          dr_rst,
    output logic [DW-1:0] port_a,
    output logic [DW-1:0] port_b,
    output logic          port_b_en,
    output logic          dr_clk
);

    logic          req_sync;
    logic          realign;
    slot_e         slot;
    logic          b_slot;
    logic [DW-1:0] pb_raw;

    smp_dr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dr_rst),
        .dout (req_sync)
    );

    smp_align_fsm u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_sync),
        .realign(realign)
    );

    smp_phase_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (realign),
        .rate_sel(rate_sel),
        .slot    (slot),
        .dr_clk  (dr_clk)
    );

    assign b_slot = (slot == PH_B0) || (slot == PH_B1);

    smp_demux_path #(.DW(DW), .LAT_A(LAT_A)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .pair_mode(ratio_sel == RATIO_PAIR),
        .b_slot   (b_slot),
        .pa       (port_a),
        .pb       (pb_raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_b_en <= 1'b0;
        end else begin
            port_b_en <= (ratio_sel == RATIO_PAIR);
        end
    end

    assign port_b = port_b_en ? pb_raw : '0;

endmodule

// File: rtl/smp_demux_chk.sv
module smp_demux_chk
    import smp_demux_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] smp_in,
    input logic          ratio_sel,
    input logic          rate_sel,
    input logic          dr_rst,
    input logic          realign,
    input logic [DW-1:0] port_a,
    input logic [DW-1:0] port_b,
    input logic          port_b_en,
    input logic          dr_clk
);

    logic       up;
    logic [3:0] since_al;
    logic [3:0] pair_cnt;
    logic [3:0] single_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up         <= 1'b0;
            since_al   <= '0;
            pair_cnt   <= '0;
            single_cnt <= '0;
        end else begin
            up         <= 1'b1;
            since_al   <= realign ? 4'd0 : ((since_al == 4'd15) ? since_al : since_al + 4'd1);
            pair_cnt   <= (ratio_sel == RATIO_PAIR) ? ((pair_cnt == 4'd15) ? pair_cnt : pair_cnt + 4'd1) : 4'd0;
            single_cnt <= (ratio_sel == RATIO_SINGLE) ? ((single_cnt == 4'd15) ? single_cnt : single_cnt + 4'd1) : 4'd0;
        end
    end

    assert_b_enable_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up |-> (port_b_en == $past(ratio_sel)));

    assert_half_rate_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_al >= 4'd2 && $past(rate_sel) == RATE_HALF && $past(rate_sel, 2) == RATE_HALF)
        |-> (dr_clk != $past(dr_clk)));

    assert_quarter_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_al >= 4'd3 && $past(rate_sel) == RATE_QUARTER && $past(rate_sel, 3) == RATE_QUARTER)
        |-> (dr_clk != $past(dr_clk, 2)));

    assert_centred_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_al >= 4'd6 && pair_cnt >= 4'd8 && $rose(dr_clk))
        |-> ($stable(port_a) && $stable(port_b)));

    assert_realign_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !dr_clk);

    assert_two_edge_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        realign |-> ($past(dr_rst, 2) && $past(dr_rst, 3)));

    assert_single_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (single_cnt >= 4'd6) |-> (port_a == $past(smp_in, 5)));

endmodule

bind smp_demux_top smp_demux_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_in   (smp_in),
    .ratio_sel(ratio_sel),
    .rate_sel (rate_sel),
    .dr_rst   (dr_rst),
    .realign  (realign),
    .port_a   (port_a),
    .port_b   (port_b),
    .port_b_en(port_b_en),
    .dr_clk   (dr_clk)
);

// File: tb/test_smp_demux_top.sv
module test_smp_demux_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int HN         = 8192;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] smp_in;
    logic          ratio_sel;
    logic          rate_sel;
    logic          dr_rst;
    logic [DW-1:0] port_a;
    logic [DW-1:0] port_b;
    logic          port_b_en;
    logic          dr_clk;

    smp_demux_top #(.DW(DW)) i_smp_demux_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .ratio_sel(ratio_sel),
        .rate_sel (rate_sel),
        .dr_rst   (dr_rst),
        .port_a   (port_a),
        .port_b   (port_b),
        .port_b_en(port_b_en),
        .dr_clk   (dr_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    int        ecount = 0;
    int        r_al   = 0;
    int        pend   = -1;
    int        m_edge = 0;
    string     dr_tag = "";
    logic [DW-1:0] hist     [HN];
    logic          rate_at  [HN];
    logic          ratio_at [HN];
    logic [DW-1:0] prev_a = '0;
    logic [DW-1:0] prev_b = '0;
    logic          prev_dr = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at edge %0d actual=%0d expected=%0d", req, ecount, act, exp);
        end
    endtask

    function automatic logic exp_dr(input int d, input logic rt);
        if (d == 0) return 1'b0;
        if (rt) return ((d % 4) >= 2);
        return ((d % 2) == 0);
    endfunction

    task automatic verify();
        int    e;
        int    d;
        int    j;
        logic  edr;
        string tg;
        e = ecount;
        if (pend == e) begin
            r_al = e;
            pend = -1;
        end
        d   = e - r_al;
        edr = exp_dr(d, rate_at[e % HN]);
        if (d == 0)            tg = "R9";
        else if (dr_tag != "") tg = dr_tag;
        else if (rate_at[e % HN]) tg = "R7";
        else                   tg = "R6";
        chk(dr_clk === edr, tg, int'(dr_clk), int'(edr));
        chk(port_b_en === ratio_at[e % HN], "R5", int'(port_b_en), int'(ratio_at[e % HN]));
        if (!ratio_at[e % HN]) chk(port_b === '0, "R5", int'(port_b), 0);
        if (d >= 5 && r_al >= m_edge) begin
            if (ratio_at[e % HN]) begin
                j = (d - 5) / 2;
                chk(port_a === hist[(r_al + 1 + 2*j) % HN], (d == 5) ? "R11" : "R2",
                    int'(port_a), int'(hist[(r_al + 1 + 2*j) % HN]));
                chk(port_b === hist[(r_al + 2 + 2*j) % HN], "R3",
                    int'(port_b), int'(hist[(r_al + 2 + 2*j) % HN]));
                if (d >= 6 && dr_clk && !prev_dr) begin
                    chk(port_a === prev_a, "R8", int'(port_a), int'(prev_a));
                    chk(port_b === prev_b, "R8", int'(port_b), int'(prev_b));
                end
            end else begin
                chk(port_a === hist[(e - 4) % HN], "R4", int'(port_a), int'(hist[(e - 4) % HN]));
            end
        end
        prev_a  = port_a;
        prev_b  = port_b;
        prev_dr = dr_clk;
    endtask

    task automatic drive(input logic [DW-1:0] v, input logic drr);
        smp_in = v;
        dr_rst = drr;
        hist[(ecount + 1) % HN]     = v;
        rate_at[(ecount + 1) % HN]  = rate_sel;
        ratio_at[(ecount + 1) % HN] = ratio_sel;
        @(posedge clk);
        ecount++;
        @(negedge clk);
        verify();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) drive(DW'($urandom), 1'b0);
    endtask

    task automatic realign_req(input int n);
        pend = ecount + 1 + 3;
        for (int i = 0; i < n; i++) drive(DW'($urandom), 1'b1);
        drive(DW'($urandom), 1'b0);
    endtask

    task automatic set_mode(input logic ra, input logic rt);
        if (ra != ratio_sel) m_edge = ecount + 1;
        ratio_sel = ra;
        rate_sel  = rt;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d edges expected=completion", ecount);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        rst_n     = 1'b0;
        smp_in    = '0;
        ratio_sel = 1'b1;
        rate_sel  = 1'b0;
        dr_rst    = 1'b0;
        for (int i = 0; i < HN; i++) begin
            hist[i] = '0; rate_at[i] = 1'b0; ratio_at[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(port_a === '0, "R1", int'(port_a), 0);
        chk(port_b === '0, "R1", int'(port_b), 0);
        chk(port_b_en === 1'b0, "R1", int'(port_b_en), 0);
        chk(dr_clk === 1'b0, "R1", int'(dr_clk), 0);
        rst_n = 1'b1;

        // Directed extremes, then random pairs at half rate (R2, R3, R6, R8, R11)
        drive(8'h00, 1'b0); drive(8'hFF, 1'b0); drive(8'hFF, 1'b0); drive(8'h00, 1'b0);
        drive(8'h55, 1'b0); drive(8'hAA, 1'b0);
        run(60);

        // Quarter rate (R7)
        set_mode(1'b1, 1'b1);
        run(40);

        // Realignment started in each of the four divider slots (R9, R11)
        for (int off = 0; off < 4; off++) begin
            run(off);
            realign_req(2);
            run(20);
        end

        // Long-held request realigns once (R12)
        dr_tag = "R12";
        realign_req(10);
        run(20);
        dr_tag = "";

        // Single-edge glitch is ignored (R10)
        dr_tag = "R10";
        drive(DW'($urandom), 1'b1);
        run(16);
        dr_tag = "";

        // Single mode at both rates (R4, R5)
        set_mode(1'b0, 1'b0);
        realign_req(2);
        run(30);
        set_mode(1'b0, 1'b1);
        run(20);

        // Random mode, rate, request lengths and glitches
        for (int seg = 0; seg < 40; seg++) begin
            set_mode(1'($urandom), 1'($urandom));
            realign_req(2 + int'($urandom % 3));
            run(15 + int'($urandom % 30));
            if (($urandom % 3) == 0) begin
                drive(DW'($urandom), 1'b1);
                run(8);
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule